// File: doc/BRIEF.md
# Fine-Grain Thread Select Unit

This unit sits in the select stage of a single-issue, six-stage pipeline: fetch, select, decode, execute, memory, writeback. Four hardware threads share the pipeline, and the unit can pick a different thread every cycle. Each thread presents three inputs:

- a flag saying it holds a valid instruction;
- the class of that instruction;
- a flag saying it is waiting on an operation that is still outstanding elsewhere.

A thread is eligible when it has a valid instruction, is not waiting, and is not blocked. Among the eligible threads, the one selected least recently wins.

The winning thread is shown as a one-hot grant. The same choice also appears as a binary index that steers fetch, so fetch has no arbiter of its own. If a granted instruction is of a long-latency class, its thread is blocked from the next cycle on. The thread stays blocked until the memory system reports completion for it.

The recency order is a full ordering of the four threads. It changes only on a grant, and the granted thread then becomes the most recent. When no thread is eligible, the unit asserts idle and grants nothing.

Top module: `thread_select_unit`

## Requirements
- R1: After reset no thread is blocked and the recency order is thread 0 (least recent), 1, 2, 3. With all threads eligible, the first grant goes to thread 0.
- R2: At most one bit of `grant` is high in any cycle. A thread is granted only when its `instValid` is 1, its `longPending` is 0, and it is not blocked.
- R3: The grant is combinational in the cycle of the inputs. Whenever a grant is given, `fetchIdx` carries the binary index of the granted thread.
- R4: Among the eligible threads, the least recently granted one wins. On each grant, the granted thread moves to most recent and the others keep their relative order.
- R5: Classes 2 (load) and 3 (long arithmetic) are long-latency; classes 0 (simple ALU) and 1 (branch) are not. The class of thread t is `instClass[2t+1:2t]`. A long-latency grant to thread t blocks t from the next cycle on.
- R6: A pulse on `doneValid` with `doneThread` = t unblocks thread t, and t can be granted in the next cycle. If that same cycle also gives t a long-latency grant, the new block wins.
- R7: While `longPending[t]` is 1, thread t is never granted, whatever its block state.
- R8: When no thread is eligible, `idle` is 1, `grant` is 0, `fetchIdx` is 0, and the recency order does not change.
- R9: A completion for a thread that is not blocked has no effect, and a grant of class 0 or 1 does not block its thread.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 4 | Per-thread flag: a valid instruction is present |
| instClass | input | 8 | Per-thread 2-bit instruction class; thread t in bits 2t+1:2t |
| longPending | input | 4 | Per-thread flag: an outstanding operation blocks this thread |
| doneValid | input | 1 | Completion notification from the memory system |
| doneThread | input | 2 | Thread that the completion belongs to |
| grant | output | 4 | One-hot select for this cycle |
| fetchIdx | output | 2 | Binary index of the granted thread, which steers fetch |
| idle | output | 1 | No thread selected this cycle |

## Verification
The assertions check on every cycle that:
- the grant is one-hot or zero;
- a granted thread is eligible;
- a long-latency grant keeps its thread out of the next cycle;
- a completion clears the block flag;
- the recency order stays a permutation of the four threads;
- the order holds still in idle cycles;
- a granted thread moves to the most recent slot.

Whether the least recent eligible thread is actually the one picked can only be shown by the bench. Its queue-based model checks every cycle of the directed sequences and of a long random run. The same applies to the exact cycle at which a completed thread comes back, and to the case where a block and a completion arrive together.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int CLASS_W = 2;

  typedef enum logic [CLASS_W-1:0] {
    ClsAlu       = 2'd0,
    ClsBranch    = 2'd1,
    ClsLoad      = 2'd2,
    ClsLongArith = 2'd3
  } inst_class_e;

  // strobes from control to the recency datapath
  typedef struct packed {
    logic promote;   // a grant was issued this cycle
    logic setBlock;  // the granted instruction is long-latency
  } tsu_strobe_t;
endpackage

// File: rtl/tsu_lru_dp.sv
module tsu_lru_dp #(
  parameter int NumThreads = 4,
  localparam int IdxW = (NumThreads > 1) ? $clog2(NumThreads) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NumThreads-1:0] eligible,
  input  tsu_pkg::tsu_strobe_t  strobes,
  input  logic [IdxW-1:0]       promoteIdx,
  output logic                  winnerValid,
  output logic [IdxW-1:0]       winnerIdx
);
  // order[0] is least recent, order[NumThreads-1] most recent
  logic [NumThreads-1:0][IdxW-1:0] order;
  logic [NumThreads-1:0][IdxW-1:0] orderNext;
  logic [NumThreads-1:0]           presentMask;
  int                              promotePos;

  // pick the first eligible thread in recency order
  always_comb begin
    winnerValid = 1'b0;
    winnerIdx   = '0;
    for (int k = NumThreads - 1; k >= 0; k--) begin
      if (eligible[order[k]]) begin
        winnerValid = 1'b1;
        winnerIdx   = order[k];
      end
    end
  end

  // remove the promoted thread and append it at the most recent end
  always_comb begin
    promotePos = 0;
    for (int k = 0; k < NumThreads; k++) begin
      if (order[k] == promoteIdx) promotePos = k;
    end
    for (int k = 0; k < NumThreads; k++) begin
      if (k < promotePos) orderNext[k] = order[k];
      else if (k < NumThreads - 1) orderNext[k] = order[k+1];
      else orderNext[k] = promoteIdx;
    end
  end

  generate
    for (genvar s = 0; s < NumThreads; s++) begin : g_slot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) order[s] <= IdxW'(s);
        else if (strobes.promote) order[s] <= orderNext[s];
      end
    end
  endgenerate

  always_comb begin
    presentMask = '0;
    for (int k = 0; k < NumThreads; k++) presentMask[order[k]] = 1'b1;
  end

  AST_ORDER_PERM: assert property (@(posedge clk) disable iff (!rstN)
    $countones(presentMask) == NumThreads); // R4
  AST_MRU_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.promote |=> order[NumThreads-1] == $past(promoteIdx)); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.promote |=> $stable(order)); // R8
endmodule

// File: rtl/tsu_ctrl.sv
module tsu_ctrl #(
  parameter int NumThreads = 4,
  parameter logic [3:0] LongClassMask = 4'b1100,
  localparam int IdxW = (NumThreads > 1) ? $clog2(NumThreads) : 1,
  localparam int ClsW = tsu_pkg::CLASS_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NumThreads-1:0]      instValid,
  input  logic [NumThreads*ClsW-1:0] instClass,
  input  logic [NumThreads-1:0]      longPending,
  input  logic                       doneValid,
  input  logic [IdxW-1:0]            doneThread,
  input  logic                       winnerValid,
  input  logic [IdxW-1:0]            winnerIdx,
  output logic [NumThreads-1:0]      eligible,
  output tsu_pkg::tsu_strobe_t       strobes
);
  logic [NumThreads-1:0] blocked;
  logic [ClsW-1:0]       winnerClass;

  assign winnerClass      = instClass[int'(winnerIdx)*ClsW +: ClsW];
  assign strobes.promote  = winnerValid;
  assign strobes.setBlock = winnerValid & LongClassMask[winnerClass];

  generate
    for (genvar t = 0; t < NumThreads; t++) begin : g_thread
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) blocked[t] <= 1'b0;
        else if (strobes.setBlock && winnerIdx == IdxW'(t)) blocked[t] <= 1'b1;
        else if (doneValid && doneThread == IdxW'(t)) blocked[t] <= 1'b0;
      end
      assign eligible[t] = instValid[t] & ~longPending[t] & ~blocked[t];
    end
  endgenerate

  AST_GRANT_ELIGIBLE: assert property (@(posedge clk) disable iff (!rstN)
    winnerValid |-> (instValid[winnerIdx] && !longPending[winnerIdx] && !blocked[winnerIdx])); // R2
  AST_LONG_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setBlock |=> !eligible[$past(winnerIdx)]); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && !(strobes.setBlock && winnerIdx == doneThread)) |=> !blocked[$past(doneThread)]); // R6
endmodule

// File: rtl/thread_select_unit.sv
module thread_select_unit #(
  parameter int NumThreads = 4,
  parameter logic [3:0] LongClassMask = 4'b1100,
  localparam int IdxW = (NumThreads > 1) ? $clog2(NumThreads) : 1,
  localparam int ClsW = tsu_pkg::CLASS_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NumThreads-1:0]      instValid,
  input  logic [NumThreads*ClsW-1:0] instClass,
  input  logic [NumThreads-1:0]      longPending,
  input  logic                       doneValid,
  input  logic [IdxW-1:0]            doneThread,
  output logic [NumThreads-1:0]      grant,
  output logic [IdxW-1:0]            fetchIdx,
  output logic                       idle
);
  logic [NumThreads-1:0] eligible;
  tsu_pkg::tsu_strobe_t  strobes;
  logic                  winnerValid;
  logic [IdxW-1:0]       winnerIdx;

  tsu_ctrl #(.NumThreads(NumThreads), .LongClassMask(LongClassMask)) u_ctrl (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .longPending(longPending), .doneValid(doneValid), .doneThread(doneThread),
    .winnerValid(winnerValid), .winnerIdx(winnerIdx),
    .eligible(eligible), .strobes(strobes)
  );

  tsu_lru_dp #(.NumThreads(NumThreads)) u_lru (
    .clk(clk), .rstN(rstN), .eligible(eligible), .strobes(strobes),
    .promoteIdx(winnerIdx), .winnerValid(winnerValid), .winnerIdx(winnerIdx)
  );

  always_comb begin
    grant = '0;
    if (winnerValid) grant[winnerIdx] = 1'b1;
  end
  assign fetchIdx = winnerValid ? winnerIdx : '0;
  assign idle     = ~winnerValid;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R2
  AST_PENDING_EXCLUDED: assert property (@(posedge clk) disable iff (!rstN)
    (grant & longPending) == '0); // R7
endmodule

// File: tb/thread_select_unit_test.sv
module thread_select_unit_test;
  localparam int ClkPeriod = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] instValid = '0;
  logic [7:0] instClass = '0;
  logic [3:0] longPending = '0;
  logic       doneValid = 1'b0;
  logic [1:0] doneThread = '0;
  logic [3:0] grant;
  logic [1:0] fetchIdx;
  logic       idle;

  int checks = 0;
  int errors = 0;
  int q[$];
  bit blk[4];

  always #(ClkPeriod/2) clk = ~clk;

  thread_select_unit uut (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .longPending(longPending), .doneValid(doneValid), .doneThread(doneThread),
    .grant(grant), .fetchIdx(fetchIdx), .idle(idle)
  );

  function automatic int modelPick(logic [3:0] v, logic [3:0] p);
    for (int k = 0; k < q.size(); k++) begin
      if (v[q[k]] && !p[q[k]] && !blk[q[k]]) return q[k];
    end
    return -1;
  endfunction

  task automatic step(input logic [3:0] v, input logic [7:0] cls, input logic [3:0] p,
                      input logic dv, input int dt, input string tag);
    int exp;
    logic [3:0] expGrant;
    logic [1:0] expIdx;
    logic expIdle;
    @(negedge clk);
    instValid = v; instClass = cls; longPending = p;
    doneValid = dv; doneThread = 2'(dt);
    #1;
    exp = modelPick(v, p);
    expGrant = (exp >= 0) ? (4'b1 << exp) : 4'b0;
    expIdx = (exp >= 0) ? 2'(exp) : 2'd0;
    expIdle = (exp < 0);
    checks++;
    if (grant !== expGrant || fetchIdx !== expIdx || idle !== expIdle) begin
      errors++;
      $display("FAIL %s grant=%b fetchIdx=%0d idle=%b expected grant=%b fetchIdx=%0d idle=%b",
               tag, grant, fetchIdx, idle, expGrant, expIdx, expIdle);
    end
    @(posedge clk);
    if (dv) blk[dt] = 1'b0;
    if (exp >= 0) begin
      for (int k = 0; k < q.size(); k++) begin
        if (q[k] == exp) begin
          q.delete(k);
          break;
        end
      end
      q.push_back(exp);
      if (cls[exp*2 +: 2] >= 2'd2) blk[exp] = 1'b1;
    end
  endtask

  initial begin
    #(ClkPeriod * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    q = {0, 1, 2, 3};
    foreach (blk[i]) blk[i] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R1: first grant after reset is thread 0
    step(4'hF, 8'h00, 4'h0, 1'b0, 0, "R1");
    // R4: rotation through recency order
    repeat (4) step(4'hF, 8'h00, 4'h0, 1'b0, 0, "R4");
    // R4: skip around partial eligibility
    step(4'b1010, 8'h00, 4'h0, 1'b0, 0, "R4");
    step(4'b1010, 8'h00, 4'h0, 1'b0, 0, "R4");
    // R8: nothing valid
    step(4'h0, 8'h00, 4'h0, 1'b0, 0, "R8");
    step(4'hF, 8'h00, 4'h0, 1'b0, 0, "R8");
    // R5: load on thread 2 (class 2) blocks it
    step(4'b0100, 8'b00_10_00_00, 4'h0, 1'b0, 0, "R5");
    step(4'b0100, 8'b00_00_00_00, 4'h0, 1'b0, 0, "R5");
    step(4'b0100, 8'h00, 4'h0, 1'b0, 0, "R5");
    // R9: completion for unblocked thread 1 has no effect, thread 2 stays blocked
    step(4'b0100, 8'h00, 4'h0, 1'b1, 1, "R9");
    step(4'b0110, 8'h00, 4'h0, 1'b0, 0, "R9");
    // R6: completion for thread 2, selectable next cycle
    step(4'b0100, 8'h00, 4'h0, 1'b1, 2, "R6");
    step(4'b0100, 8'h00, 4'h0, 1'b0, 0, "R6");
    // R5: long arithmetic (class 3) on thread 0
    step(4'b0001, 8'b00_00_00_11, 4'h0, 1'b0, 0, "R5");
    step(4'b0001, 8'h00, 4'h0, 1'b0, 0, "R5");
    // R6: block and completion for the same thread in one cycle, block wins
    step(4'b0001, 8'h00, 4'h0, 1'b1, 0, "R6");
    step(4'b0001, 8'b00_00_00_10, 4'h0, 1'b1, 0, "R6");
    step(4'b0001, 8'h00, 4'h0, 1'b0, 0, "R6");
    step(4'b0001, 8'h00, 4'h0, 1'b1, 0, "R6");
    // R9: branch class does not block
    step(4'b1000, 8'b01_00_00_00, 4'h0, 1'b0, 0, "R9");
    step(4'b1000, 8'h00, 4'h0, 1'b0, 0, "R9");
    // R7: pending flag excludes thread
    step(4'hF, 8'h00, 4'b1111, 1'b0, 0, "R7");
    step(4'hF, 8'h00, 4'b1110, 1'b0, 0, "R7");
    step(4'b0010, 8'h00, 4'b0010, 1'b0, 0, "R7");
    // R2/R3: random traffic
    for (int n = 0; n < 600; n++) begin
      logic [3:0] rv;
      logic [7:0] rc;
      logic [3:0] rp;
      rv = 4'($urandom);
      rc = 8'($urandom);
      rp = ($urandom % 4 == 0) ? 4'($urandom) : 4'h0;
      step(rv, rc, rp, 1'($urandom % 3 == 0), int'($urandom % 4), "R2");
    end
    // R3: fetch index follows grant
    for (int t = 0; t < 4; t++) step(4'b1 << t, 8'h00, 4'h0, 1'b1, t, "R3");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule